// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter that sits behind a three-wire serial port. The falling edge of an active-low select opens a frame. The track/hold moves into hold and the data output leaves high impedance and drives low. Each rising edge of the serial clock then moves the frame on by one step. On the early edges the block decides one result bit from an ideal comparator input and updates the trial code that it presents to the capacitive DAC. On later edges it shifts a bit out on the serial line.

The serial frame has a fixed shape. Two leading zeros come first. The most significant result bit follows on the third rising edge, and the remaining nine bits come after it, most significant first. Two sub-bits follow the data, and zeros fill every further edge while the select stays low. The result is plain unipolar binary, so one code step is the reference divided by 1024. Raising the select at any point ends the frame and aborts an unfinished conversion. Holding the shutdown pin low keeps the block idle.

The pins arrive asynchronously. Each one passes through a synchronizer clocked by the system clock, and all outputs are registered.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, `dout_oe`, `dout`, `hold` and `dac_code` are all 0.
- R2: With `shdn_n` high, a falling edge on `cs_n` sets `dout_oe` to 1, `dout` to 0, `hold` to 1, and the trial code to 10'h200 (only the top bit set).
- R3: While `cs_n` is high, `dout_oe` is 0 and `hold` is 0.
- R4: `dout` changes only in response to a rising serial-clock edge, a select edge, or shutdown. A falling serial-clock edge leaves it unchanged.
- R5: Counting rising edges from 1 after the select falls, edges 1 and 2 drive `dout` to 0, and edge 3 drives result bit 9 (the MSB).
- R6: Edges 3 through 12 drive result bits 9 down to 0 in that order. The result equals the input code in unsigned binary, floor(Vin·1024/Vref).
- R7: Edge 13 drives sub-bit S1 and edge 14 drives sub-bit S0. S1 is the comparator input sampled on edge 12 and S0 is the comparator input sampled on edge 13.
- R8: Edge 15 and every later edge, while the select stays low, drive 0 and leave `dac_code` unchanged.
- R9: On edge k, for k from 2 to 11, bit 11−k of the trial code takes the comparator input and bit 10−k (if it exists) is set to 1. After edge 11 the trial code holds the final result.
- R10: `hold` stays 1 from the select falling edge through edge 12 and returns to 0 on edge 13.
- R11: Raising the select before the frame ends aborts it. `hold`, `dout_oe` and `dac_code` return to 0, and the next falling edge starts a fresh frame from edge 1.
- R12: While `shdn_n` is low, select falling edges are ignored, `dout_oe` and `hold` are 0, `dac_code` is 0, and any frame in progress is aborted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; a falling edge starts a frame |
| sclk | input | 1 | Serial clock; rising edges step the frame |
| shdn_n | input | 1 | Active-low shutdown |
| cmp_hi | input | 1 | Comparator decision: 1 when the held input is at or above the trial level |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Output enable for the data pin; 0 means high impedance |
| hold | output | 1 | Track/hold control; 1 means hold |
| dac_code | output | 10 | Trial code to the capacitive DAC |

## Verification
Each pin change passes through two synchronizer stages and one edge-detect register before the registered outputs respond. As a result, `dout`, `dout_oe`, `hold` and `dac_code` take their new values on the third system-clock edge after the pin moves. The bench drives every pin on a falling clock edge and waits exactly three rising edges. It samples on the following falling edge and pushes the expected values of that instant into the scoreboard just before the monitor compares them. The comparator is modelled as the ideal comparison of an input code against `dac_code`, which the bench can override on the sub-bit edges. Because the model follows the trial code that the previous edge registered, every decision and every shifted bit can be predicted edge by edge from the input code alone.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Pin bundle passed through the synchronizer as one vector.
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic shdn_n;
  } pin_bundle_t;

  // Which part of the serial frame a given rising-edge number falls in.
  typedef enum logic [1:0] {
    PH_LEAD,
    PH_DATA,
    PH_SUB,
    PH_TRAIL
  } frame_phase_e;

  function automatic frame_phase_e phase_of(int edge_no, int lead, int nbits, int nsub);
    if (edge_no <= lead)                return PH_LEAD;
    else if (edge_no <= lead + nbits)   return PH_DATA;
    else if (edge_no <= lead + nbits + nsub) return PH_SUB;
    else                                return PH_TRAIL;
  endfunction

endpackage

// File: rtl/sar_pin_sync.sv
module sar_pin_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] d_sync
);

  logic [STAGES-1:0][W-1:0] stage_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) stage_q[0] <= RST_VAL;
      else     stage_q[0] <= d_raw;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q <= {STAGES{RST_VAL}};
      else     stage_q <= {stage_q[STAGES-2:0], d_raw};
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_BITS  = 10,
  parameter int LEAD_ZEROS = 2,
  parameter int SUB_BITS   = 2,
  parameter int CNT_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_lvl,
  input  logic                 sclk_lvl,
  input  logic                 shdn_lvl,
  input  logic [DATA_BITS-1:0] code,
  input  logic [SUB_BITS-1:0]  sub_bits,
  output logic                 start,
  output logic                 stop,
  output logic                 rise_en,
  output logic [CNT_W-1:0]     edge_num,
  output logic                 dout,
  output logic                 dout_oe
);

  localparam int LAST_DATA = LEAD_ZEROS + DATA_BITS;
  localparam int LAST_SUB  = LAST_DATA + SUB_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LAST_SUB + 1);

  logic             cs_prev_q;
  logic             sclk_prev_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dout_q;
  logic             oe_q;
  logic             bit_sel;
  frame_phase_e     phase;
  int               e_i;

  // Frame control events derived from synchronized pin levels.
  assign start   = cs_prev_q & ~cs_lvl & shdn_lvl;
  assign stop    = cs_lvl | ~shdn_lvl;
  assign rise_en = sclk_lvl & ~sclk_prev_q & active_q & ~stop & ~start;

  // Edge number this rising edge represents (saturates in the trailing zone).
  assign edge_num = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    e_i     = int'(edge_num);
    phase   = phase_of(e_i, LEAD_ZEROS, DATA_BITS, SUB_BITS);
    bit_sel = 1'b0;
    case (phase)
      PH_DATA: begin
        for (int b = 0; b < DATA_BITS; b++) begin
          if (b == LAST_DATA - e_i) bit_sel = code[b];
        end
      end
      PH_SUB: begin
        for (int b = 0; b < SUB_BITS; b++) begin
          if (b == LAST_SUB - e_i) bit_sel = sub_bits[b];
        end
      end
      default: bit_sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_lvl;
      sclk_prev_q <= sclk_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (stop) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b1;
    end else if (rise_en) begin
      cnt_q  <= edge_num;
      dout_q <= bit_sel;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;

  // R3
  cs_high_float_chk: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> !oe_q)
    else $error("data output enabled while select high");

  // R12
  shdn_float_chk: assert property (@(posedge clk) disable iff (rst)
    !shdn_lvl |=> !oe_q)
    else $error("data output enabled during shutdown");

  // R4
  dout_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise_en && !start && !stop) |=> $stable(dout_q))
    else $error("data output moved without a serial clock rise");

  // R2
  start_drive_low_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (oe_q && !dout_q))
    else $error("frame start did not drive a low level");

endmodule

// File: rtl/sar_decide.sv
module sar_decide #(
  parameter int DATA_BITS  = 10,
  parameter int LEAD_ZEROS = 2,
  parameter int SUB_BITS   = 2,
  parameter int CNT_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 stop,
  input  logic                 rise_en,
  input  logic [CNT_W-1:0]     edge_num,
  input  logic                 cmp,
  output logic [DATA_BITS-1:0] code,
  output logic [SUB_BITS-1:0]  sub_bits,
  output logic                 hold
);

  localparam int FIRST_DEC = LEAD_ZEROS;
  localparam int LAST_DEC  = LEAD_ZEROS + DATA_BITS - 1;
  localparam int LAST_DATA = LEAD_ZEROS + DATA_BITS;
  localparam int HOLD_END  = LAST_DATA + SUB_BITS - 1;
  localparam int IDX_W     = $clog2(DATA_BITS);
  localparam logic [DATA_BITS-1:0] TRIAL_INIT = DATA_BITS'(1) << (DATA_BITS - 1);

  logic [DATA_BITS-1:0] code_q, code_nxt;
  logic [SUB_BITS-1:0]  sub_q, sub_nxt;
  logic                 hold_q;
  logic                 in_dec;
  logic                 at_hold_end;
  int                   e_i;
  int                   idx;

  always_comb begin
    e_i         = int'(edge_num);
    idx         = LAST_DEC - e_i;
    in_dec      = (e_i >= FIRST_DEC) && (e_i <= LAST_DEC);
    at_hold_end = (e_i == HOLD_END);
    code_nxt    = code_q;
    sub_nxt     = sub_q;
    if (in_dec) begin
      for (int b = 0; b < DATA_BITS; b++) begin
        if (b == idx)          code_nxt[b] = cmp;
        else if (b == idx - 1) code_nxt[b] = 1'b1;
      end
    end
    if ((e_i >= LAST_DATA) && (e_i <= HOLD_END)) begin
      for (int b = 0; b < SUB_BITS; b++) begin
        if (b == HOLD_END - e_i) sub_nxt[b] = cmp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      sub_q  <= '0;
      hold_q <= 1'b0;
    end else if (stop) begin
      code_q <= '0;
      sub_q  <= '0;
      hold_q <= 1'b0;
    end else if (start) begin
      code_q <= TRIAL_INIT;
      sub_q  <= '0;
      hold_q <= 1'b1;
    end else if (rise_en) begin
      code_q <= code_nxt;
      sub_q  <= sub_nxt;
      if (at_hold_end) hold_q <= 1'b0;
    end
  end

  assign code     = code_q;
  assign sub_bits = sub_q;
  assign hold     = hold_q;

  // Record of the most recent decision, kept for the bit-decision check.
  logic             dec_q;
  logic [IDX_W-1:0] dec_idx_q;
  logic             dec_cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q     <= 1'b0;
      dec_idx_q <= '0;
      dec_cmp_q <= 1'b0;
    end else begin
      dec_q     <= rise_en && in_dec;
      dec_idx_q <= IDX_W'(idx);
      dec_cmp_q <= cmp;
    end
  end

  // R9
  bit_decide_chk: assert property (@(posedge clk) disable iff (rst)
    dec_q |-> (code_q[dec_idx_q] == dec_cmp_q))
    else $error("decided bit does not match comparator");

  // R2
  trial_init_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (code_q == TRIAL_INIT) && hold_q)
    else $error("frame start trial code or hold wrong");

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_en && at_hold_end) |=> !hold_q)
    else $error("hold not released after last comparator sample");

  // R11
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!hold_q && (code_q == '0)))
    else $error("abort left conversion state behind");

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_BITS   = 10,
  parameter int LEAD_ZEROS  = 2,
  parameter int SUB_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 shdn_n,
  input  logic                 cmp_hi,
  output logic                 dout,
  output logic                 dout_oe,
  output logic                 hold,
  output logic [DATA_BITS-1:0] dac_code
);

  localparam int FRAME_LEN = LEAD_ZEROS + DATA_BITS + SUB_BITS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam int PIN_W     = $bits(pin_bundle_t);
  localparam pin_bundle_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b0, shdn_n: 1'b1};

  pin_bundle_t          raw_pins;
  pin_bundle_t          sync_pins;
  logic [PIN_W-1:0]     sync_vec;
  logic                 start, stop, rise_en;
  logic [CNT_W-1:0]     edge_num;
  logic [DATA_BITS-1:0] code;
  logic [SUB_BITS-1:0]  sub_bits;

  assign raw_pins.cs_n   = cs_n;
  assign raw_pins.sclk   = sclk;
  assign raw_pins.shdn_n = shdn_n;

  sar_pin_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_raw  (raw_pins),
    .d_sync (sync_vec)
  );

  assign sync_pins = sync_vec;

  sar_frame_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .LEAD_ZEROS (LEAD_ZEROS),
    .SUB_BITS   (SUB_BITS),
    .CNT_W      (CNT_W)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .cs_lvl   (sync_pins.cs_n),
    .sclk_lvl (sync_pins.sclk),
    .shdn_lvl (sync_pins.shdn_n),
    .code     (code),
    .sub_bits (sub_bits),
    .start    (start),
    .stop     (stop),
    .rise_en  (rise_en),
    .edge_num (edge_num),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  sar_decide #(
    .DATA_BITS  (DATA_BITS),
    .LEAD_ZEROS (LEAD_ZEROS),
    .SUB_BITS   (SUB_BITS),
    .CNT_W      (CNT_W)
  ) u_decide (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stop     (stop),
    .rise_en  (rise_en),
    .edge_num (edge_num),
    .cmp      (cmp_hi),
    .code     (code),
    .sub_bits (sub_bits),
    .hold     (hold)
  );

  assign dac_code = code;

endmodule

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;

  localparam int N         = 10;
  localparam int LAST_DEC  = 11;
  localparam int LAST_DATA = 12;
  localparam int HOLD_END  = 13;
  localparam int LAST_SUB  = 14;
  localparam int F_DOUT = 0, F_OE = 1, F_HOLD = 2, F_CODE = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         shdn_n = 1'b1;
  logic [N-1:0] vin = '0;
  logic         frc_en = 1'b0;
  logic         frc_val = 1'b0;
  logic         cmp_hi;
  logic         dout, dout_oe, hold;
  logic [N-1:0] dac_code;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  event due;

  string req_q[$];
  int    fld_q[$];
  int    val_q[$];

  always #2 clk = ~clk;

  // Ideal comparator with an override used on the sub-bit edges.
  assign cmp_hi = frc_en ? frc_val : (vin >= dac_code);

  sar_adc_seq u_dut (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .shdn_n   (shdn_n),
    .cmp_hi   (cmp_hi),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .hold     (hold),
    .dac_code (dac_code)
  );

  task automatic push(string r, int f, int v);
    req_q.push_back(r);
    fld_q.push_back(f);
    val_q.push_back(v);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(due);
      while (req_q.size() > 0) begin
        string r;
        int f, v, a;
        r = req_q.pop_front();
        f = fld_q.pop_front();
        v = val_q.pop_front();
        case (f)
          F_DOUT:  a = int'(dout);
          F_OE:    a = int'(dout_oe);
          F_HOLD:  a = int'(hold);
          default: a = int'(dac_code);
        endcase
        n_chk++;
        if (a != v) begin
          n_fail++;
          $display("FAIL %s field=%0d actual=%0h expected=%0h", r, f, a, v);
        end
      end
    end
  end

  function automatic int exp_code(int vi, int e);
    int idx;
    if (e < 2) return 512;
    if (e >= LAST_DEC) return vi;
    idx = LAST_DEC - e;
    return (vi & ~((1 << idx) - 1)) | (1 << (idx - 1));
  endfunction

  task automatic cs_fall_chk();
    cs_n = 1'b0;
    settle();
    push("R2", F_OE, 1);
    push("R2", F_DOUT, 0);
    push("R2", F_HOLD, 1);
    push("R2", F_CODE, 512);
    -> due;
  endtask

  task automatic cs_rise_chk();
    cs_n = 1'b1;
    settle();
    push("R3", F_OE, 0);
    push("R3", F_HOLD, 0);
    push("R11", F_CODE, 0);
    -> due;
  endtask

  task automatic clk_edge(int e, bit fen, bit s1, bit s0);
    int vi, expd;
    string dreq, creq;
    vi = int'(vin);
    frc_en  = fen && (e == LAST_DATA || e == HOLD_END);
    frc_val = (e == LAST_DATA) ? s1 : s0;
    sclk = 1'b1;
    settle();
    if (e < 3)                 begin expd = 0; dreq = "R5"; end
    else if (e <= LAST_DATA)   begin expd = (vi >> (LAST_DATA - e)) & 1; dreq = (e == 3) ? "R5" : "R6"; end
    else if (e == HOLD_END)    begin expd = fen ? int'(s1) : 1; dreq = "R7"; end
    else if (e == LAST_SUB)    begin expd = fen ? int'(s0) : 1; dreq = "R7"; end
    else                       begin expd = 0; dreq = "R8"; end
    creq = (e > LAST_SUB) ? "R8" : "R9";
    push(dreq, F_DOUT, expd);
    push("R2", F_OE, 1);
    push("R10", F_HOLD, (e < HOLD_END) ? 1 : 0);
    push(creq, F_CODE, exp_code(vi, e));
    -> due;
    frc_en = 1'b0;
    sclk = 1'b0;
    settle();
    push("R4", F_DOUT, expd);
    -> due;
  endtask

  task automatic run_frame(int v, int nedges, bit fen, bit s1, bit s0, bit close);
    vin = N'(v);
    cs_fall_chk();
    for (int e = 1; e <= nedges; e++) clk_edge(e, fen, s1, s0);
    if (close) cs_rise_chk();
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    push("R1", F_OE, 0);
    push("R1", F_DOUT, 0);
    push("R1", F_HOLD, 0);
    push("R1", F_CODE, 0);
    -> due;

    // Full frame with trailing zeros and overridden sub-bits (R5..R10)
    run_frame(10'h2A5, 16, 1'b1, 1'b0, 1'b1, 1'b1);
    // Full scale, stops right after S0
    run_frame(10'h3FF, 14, 1'b0, 1'b0, 1'b0, 1'b1);
    // Zero scale with trailing edges (R8)
    run_frame(10'h000, 16, 1'b1, 1'b1, 1'b0, 1'b1);

    // R11 abort mid-conversion, then a clean frame
    run_frame(10'h155, 6, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame(10'h0F0, 15, 1'b0, 1'b0, 1'b0, 1'b1);

    // R12 shutdown: select fall ignored, clocks ignored
    shdn_n = 1'b0;
    settle();
    push("R12", F_OE, 0);
    push("R12", F_HOLD, 0);
    -> due;
    cs_n = 1'b0;
    settle();
    push("R12", F_OE, 0);
    push("R12", F_HOLD, 0);
    push("R12", F_CODE, 0);
    -> due;
    sclk = 1'b1;
    settle();
    push("R12", F_OE, 0);
    push("R12", F_DOUT, 0);
    push("R12", F_CODE, 0);
    -> due;
    sclk = 1'b0;
    shdn_n = 1'b1;
    settle();
    push("R12", F_OE, 0);
    push("R12", F_HOLD, 0);
    -> due;
    cs_n = 1'b1;
    settle();

    // R12 shutdown in the middle of a frame aborts it
    run_frame(10'h1C3, 5, 1'b0, 1'b0, 1'b0, 1'b0);
    shdn_n = 1'b0;
    settle();
    push("R12", F_OE, 0);
    push("R12", F_HOLD, 0);
    push("R12", F_CODE, 0);
    -> due;
    cs_n = 1'b1;
    shdn_n = 1'b1;
    settle();

    // Recovery frame after shutdown
    run_frame(10'h1C3, 14, 1'b0, 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule